// File: doc/BRIEF.md
# Four-Channel Converter Register Interface

This block is the serial control front end of a four-channel output converter. A host drives it as an SPI slave with 24-bit command frames. Each frame either writes a register or asks for a register to be read back. The block keeps a code, a gain trim and an offset trim for every channel. It also keeps a set of control words, some per channel and some shared by the device. Its parallel outputs drive the analog sections directly; the conversion itself, the boost supply and the ramp engine are elsewhere.

Writes and reads use separate address maps. For control writes, the sub-register is chosen by a selector field inside the data word, not by the address. A read takes two frames. The first frame names the register. The host then deselects, and during a second frame, normally a no-op, the block shifts out the value it captured when the request arrived. SCLK, chip select and MOSI are sampled by the system clock, so SCLK must run well below that clock.

Top module: `quad_dac_regif`

## Requirements
- R1: Frames are 24 bits, MSB first, in SPI mode 1: MOSI is sampled on SCLK falling edges and MISO changes on SCLK rising edges. Frame bit 23 is the read flag, bits 20:16 are the address, bits 15:0 are the data, and bits 22:21 must be zero.
- R2: A frame is acted upon only if exactly 24 SCLK falling edges occur while chip select is low. A shorter or longer frame writes nothing and does not start a read.
- R3: A write to address 0x00+c loads the code of channel c, 0x08+c loads its gain trim, and 0x10+c loads its offset trim (c = 0..3). All 16 data bits are stored.
- R4: A write to 0x1C+c is a control write. Data bits 15:13 select the target and bits 12:0 carry the value. Selector 0 is the ramp word of channel c (13 bits). Selector 2 is the channel control word of channel c. Selectors 1, 3 and 4 are the shared main, boost-supply and software words (13 bits each), whatever c is.
- R5: The channel control word keeps only value bits 8:0. Bit 8 is internal enable, 7 clear enable, 6 output enable, 5 internal sense resistor, 4 boost enable, 3 overrange enable, and 2:0 range mode.
- R6: A write is ignored and changes no output if any of these holds: the address is 0x04–0x07, 0x0C–0x0F or 0x14–0x1B; the control selector is 5, 6 or 7; or frame bits 22:21 are not zero.
- R7: After reset every code, control word and ramp word is zero, every gain trim is 0xFFFF, every offset trim is 0x8000, and MISO is low.
- R8: A read request captures the addressed value at the end of the request frame. The next valid frame shifts it out on MISO in bits 15:0, with bits 23:16 zero. Reads use these addresses: code 0x00+c, channel control 0x04+c, gain 0x08+c, offset 0x0C+c, ramp 0x14+c, status input 0x18, main 0x19, boost 0x1A.
- R9: Reads of the clear-code addresses 0x10–0x13, of 0x1B–0x1F, or of any address with bits 22:21 set return zero.
- R10: The no-op frame 0x1CE000 changes no register. A frame sent with no read pending shifts out all zeros.
- R11: A pending answer is sent once. It is replaced by the next read request, or dropped by any other valid frame. A read frame never writes.
- R12: MISO is low whenever chip select is deasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| status_i | input | 16 | Status word returned by read address 0x18 |
| dac_code_o | output | 64 | Four channel codes, channel c at bits 16c+15:16c |
| gain_o | output | 64 | Four gain trims, same packing |
| offset_o | output | 64 | Four offset trims, same packing |
| dac_ctl_o | output | 36 | Four channel control words, channel c at bits 9c+8:9c |
| slew_o | output | 52 | Four ramp words, channel c at bits 13c+12:13c |
| main_ctl_o | output | 13 | Shared main control word |
| dcdc_ctl_o | output | 13 | Shared boost-supply control word |
| sw_ctl_o | output | 13 | Shared software control word |

## Verification
The hardest case is the state of the pending read when the response frame is not a no-op. That frame may itself be a write, a second read, or a frame with the wrong bit count. Each case has its own answer: the captured value must still come out, and the frame's own effect must follow. The bench uses a serial task with a variable bit count and chains frames. It reads a code and then overwrites that code in the response frame, to show the value was captured at request time. It sends two reads back to back. It sends a malformed read before a no-op, to show that no answer was armed.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
    localparam int FRAME_W  = 24;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 5;
    localparam int NCH      = 4;
    localparam int CH_W     = $clog2(NCH);
    localparam int SUBV_W   = 13;
    localparam int DACCTL_W = 9;
    localparam int CNT_W    = $clog2(FRAME_W + 1);

    localparam logic [DATA_W-1:0] GAIN_RST = 16'hFFFF;
    localparam logic [DATA_W-1:0] OFFS_RST = 16'h8000;

    // frame field positions
    localparam int RD_BIT   = 23;
    localparam int RSV_HI   = 22;
    localparam int RSV_LO   = 21;
    localparam int ADDR_HI  = 20;
    localparam int ADDR_LO  = 16;
    localparam int SEL_HI   = 15;
    localparam int SEL_LO   = 13;

    typedef enum logic [2:0] {
        SEL_SLEW   = 3'd0,
        SEL_MAIN   = 3'd1,
        SEL_DACCTL = 3'd2,
        SEL_DCDC   = 3'd3,
        SEL_SWCMD  = 3'd4
    } ctl_sel_e;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_READ,
        OP_DATA,
        OP_GAIN,
        OP_OFFS,
        OP_SLEW,
        OP_MAIN,
        OP_DACCTL,
        OP_DCDC,
        OP_SWCMD
    } cmd_op_e;

    typedef struct packed {
        cmd_op_e             op;
        logic [CH_W-1:0]     chan;
        logic [ADDR_W-1:0]   addr;
        logic [SUBV_W-1:0]   sval;
        logic [DATA_W-1:0]   val;
    } cmd_t;

    function automatic cmd_t decode_frame(input logic [FRAME_W-1:0] f);
        cmd_t c;
        logic [ADDR_W-1:0] a;
        a      = f[ADDR_HI:ADDR_LO];
        c.op   = OP_NONE;
        c.addr = a;
        c.chan = a[CH_W-1:0];
        c.val  = f[DATA_W-1:0];
        c.sval = f[SUBV_W-1:0];
        if (f[RSV_HI:RSV_LO] == 2'b00) begin
            if (f[RD_BIT]) begin
                c.op = OP_READ;
            end else begin
                case (a[ADDR_W-1:CH_W])
                    3'b000: c.op = OP_DATA;
                    3'b010: c.op = OP_GAIN;
                    3'b100: c.op = OP_OFFS;
                    3'b111: begin
                        case (ctl_sel_e'(f[SEL_HI:SEL_LO]))
                            SEL_SLEW:   c.op = OP_SLEW;
                            SEL_MAIN:   c.op = OP_MAIN;
                            SEL_DACCTL: c.op = OP_DACCTL;
                            SEL_DCDC:   c.op = OP_DCDC;
                            SEL_SWCMD:  c.op = OP_SWCMD;
                            default:    c.op = OP_NONE;
                        endcase
                    end
                    default: c.op = OP_NONE;
                endcase
            end
        end
        return c;
    endfunction
endpackage

// File: rtl/qdac_spi_link.sv
module qdac_spi_link
    import qdac_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sclk_i,
    input  logic                cs_n_i,
    input  logic                mosi_i,
    input  logic [DATA_W-1:0]   resp_i,
    input  logic                resp_vld_i,
    output logic                miso_o,
    output logic                frm_vld_o,
    output logic [FRAME_W-1:0]  frm_o
);
    localparam int PAD_W = FRAME_W - DATA_W;

    // synchronisers; the extra stage on sclk and cs gives the previous value
    logic [SYNC_STAGES:0]   sclk_sh;
    logic [SYNC_STAGES:0]   cs_sh;
    logic [SYNC_STAGES-1:0] mosi_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_sh <= '0;
            cs_sh   <= '1;
            mosi_sh <= '0;
        end else begin
            sclk_sh <= {sclk_sh[SYNC_STAGES-1:0], sclk_i};
            cs_sh   <= {cs_sh[SYNC_STAGES-1:0], cs_n_i};
            mosi_sh <= {mosi_sh[SYNC_STAGES-2:0], mosi_i};
        end
    end

    logic sclk_now, sclk_prev, sel_now, sel_prev, mosi_now;
    logic sclk_rise, sclk_fall, sel_start, sel_end;

    assign sclk_now  = sclk_sh[SYNC_STAGES-1];
    assign sclk_prev = sclk_sh[SYNC_STAGES];
    assign sel_now   = ~cs_sh[SYNC_STAGES-1];
    assign sel_prev  = ~cs_sh[SYNC_STAGES];
    assign mosi_now  = mosi_sh[SYNC_STAGES-1];
    assign sclk_rise = sclk_now & ~sclk_prev;
    assign sclk_fall = ~sclk_now & sclk_prev;
    assign sel_start = sel_now & ~sel_prev;
    assign sel_end   = ~sel_now & sel_prev;

    logic [CNT_W-1:0]   bit_cnt;
    logic               too_long;
    logic [FRAME_W-1:0] rx_sr;
    logic [FRAME_W-1:0] tx_sr;
    logic               miso_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt   <= '0;
            too_long  <= 1'b0;
            rx_sr     <= '0;
            tx_sr     <= '0;
            miso_q    <= 1'b0;
            frm_vld_o <= 1'b0;
            frm_o     <= '0;
        end else begin
            frm_vld_o <= 1'b0;
            if (sel_start) begin
                bit_cnt  <= '0;
                too_long <= 1'b0;
                miso_q   <= 1'b0;
                tx_sr    <= resp_vld_i ? {{PAD_W{1'b0}}, resp_i} : '0;
            end else if (sel_now) begin
                if (sclk_rise) begin
                    miso_q <= tx_sr[FRAME_W-1];
                    tx_sr  <= {tx_sr[FRAME_W-2:0], 1'b0};
                end
                if (sclk_fall) begin
                    rx_sr <= {rx_sr[FRAME_W-2:0], mosi_now};
                    if (bit_cnt == CNT_W'(FRAME_W)) begin
                        too_long <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
            end else if (sel_end) begin
                miso_q <= 1'b0;
                if (bit_cnt == CNT_W'(FRAME_W) && !too_long) begin
                    frm_vld_o <= 1'b1;
                    frm_o     <= rx_sr;
                end
            end
        end
    end

    assign miso_o = miso_q;
endmodule

// File: rtl/qdac_cmd_decode.sv
module qdac_cmd_decode
    import qdac_pkg::*;
(
    input  logic [FRAME_W-1:0] frame_i,
    output cmd_t               cmd_o
);
    always_comb begin
        cmd_o = decode_frame(frame_i);
    end
endmodule

// File: rtl/qdac_regbank.sv
module qdac_regbank
    import qdac_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     frm_vld_i,
    input  cmd_t                     cmd_i,
    input  logic [DATA_W-1:0]        status_i,
    output logic [NCH*DATA_W-1:0]    data_o,
    output logic [NCH*DATA_W-1:0]    gain_o,
    output logic [NCH*DATA_W-1:0]    offs_o,
    output logic [NCH*DACCTL_W-1:0]  dacctl_o,
    output logic [NCH*SUBV_W-1:0]    slew_o,
    output logic [SUBV_W-1:0]        main_o,
    output logic [SUBV_W-1:0]        dcdc_o,
    output logic [SUBV_W-1:0]        swcmd_o,
    output logic [DATA_W-1:0]        resp_o,
    output logic                     resp_vld_o
);
    logic [DATA_W-1:0]   rd_data [NCH];
    logic [DATA_W-1:0]   rd_gain [NCH];
    logic [DATA_W-1:0]   rd_offs [NCH];
    logic [DACCTL_W-1:0] rd_ctl  [NCH];
    logic [SUBV_W-1:0]   rd_slew [NCH];

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic                hit;
        logic [DATA_W-1:0]   data_r, gain_r, offs_r;
        logic [DACCTL_W-1:0] ctl_r;
        logic [SUBV_W-1:0]   slew_r;

        assign hit = frm_vld_i && (cmd_i.chan == CH_W'(ch));

        always_ff @(posedge clk) begin
            if (rst) begin
                data_r <= '0;
                gain_r <= GAIN_RST;
                offs_r <= OFFS_RST;
                ctl_r  <= '0;
                slew_r <= '0;
            end else if (hit) begin
                case (cmd_i.op)
                    OP_DATA:   data_r <= cmd_i.val;
                    OP_GAIN:   gain_r <= cmd_i.val;
                    OP_OFFS:   offs_r <= cmd_i.val;
                    OP_DACCTL: ctl_r  <= cmd_i.sval[DACCTL_W-1:0];
                    OP_SLEW:   slew_r <= cmd_i.sval;
                    default:   ;
                endcase
            end
        end

        assign data_o[ch*DATA_W +: DATA_W]       = data_r;
        assign gain_o[ch*DATA_W +: DATA_W]       = gain_r;
        assign offs_o[ch*DATA_W +: DATA_W]       = offs_r;
        assign dacctl_o[ch*DACCTL_W +: DACCTL_W] = ctl_r;
        assign slew_o[ch*SUBV_W +: SUBV_W]       = slew_r;
        assign rd_data[ch] = data_r;
        assign rd_gain[ch] = gain_r;
        assign rd_offs[ch] = offs_r;
        assign rd_ctl[ch]  = ctl_r;
        assign rd_slew[ch] = slew_r;
    end

    // device-wide control words
    always_ff @(posedge clk) begin
        if (rst) begin
            main_o  <= '0;
            dcdc_o  <= '0;
            swcmd_o <= '0;
        end else if (frm_vld_i) begin
            case (cmd_i.op)
                OP_MAIN:  main_o  <= cmd_i.sval;
                OP_DCDC:  dcdc_o  <= cmd_i.sval;
                OP_SWCMD: swcmd_o <= cmd_i.sval;
                default:  ;
            endcase
        end
    end

    // readback selection, read map differs from the write map
    logic [DATA_W-1:0] rd_val;

    always_comb begin
        rd_val = '0;
        case (cmd_i.addr[ADDR_W-1:CH_W])
            3'b000: rd_val = rd_data[cmd_i.chan];
            3'b001: rd_val = {{(DATA_W-DACCTL_W){1'b0}}, rd_ctl[cmd_i.chan]};
            3'b010: rd_val = rd_gain[cmd_i.chan];
            3'b011: rd_val = rd_offs[cmd_i.chan];
            3'b101: rd_val = {{(DATA_W-SUBV_W){1'b0}}, rd_slew[cmd_i.chan]};
            3'b110: begin
                case (cmd_i.addr[CH_W-1:0])
                    2'b00:   rd_val = status_i;
                    2'b01:   rd_val = {{(DATA_W-SUBV_W){1'b0}}, main_o};
                    2'b10:   rd_val = {{(DATA_W-SUBV_W){1'b0}}, dcdc_o};
                    default: rd_val = '0;
                endcase
            end
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_o     <= '0;
            resp_vld_o <= 1'b0;
        end else if (frm_vld_i) begin
            if (cmd_i.op == OP_READ) begin
                resp_o     <= rd_val;
                resp_vld_o <= 1'b1;
            end else begin
                resp_vld_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/quad_dac_regif.sv
module quad_dac_regif
    import qdac_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sclk,
    input  logic                     cs_n,
    input  logic                     mosi,
    output logic                     miso,
    input  logic [DATA_W-1:0]        status_i,
    output logic [NCH*DATA_W-1:0]    dac_code_o,
    output logic [NCH*DATA_W-1:0]    gain_o,
    output logic [NCH*DATA_W-1:0]    offset_o,
    output logic [NCH*DACCTL_W-1:0]  dac_ctl_o,
    output logic [NCH*SUBV_W-1:0]    slew_o,
    output logic [SUBV_W-1:0]        main_ctl_o,
    output logic [SUBV_W-1:0]        dcdc_ctl_o,
    output logic [SUBV_W-1:0]        sw_ctl_o
);
    logic               frm_vld;
    logic [FRAME_W-1:0] frm_word;
    logic [DATA_W-1:0]  resp;
    logic               resp_vld;
    cmd_t               cmd;

    qdac_spi_link #(.SYNC_STAGES(2)) i_link (
        .clk        (clk),
        .rst        (rst),
        .sclk_i     (sclk),
        .cs_n_i     (cs_n),
        .mosi_i     (mosi),
        .resp_i     (resp),
        .resp_vld_i (resp_vld),
        .miso_o     (miso),
        .frm_vld_o  (frm_vld),
        .frm_o      (frm_word)
    );

    qdac_cmd_decode i_dec (
        .frame_i (frm_word),
        .cmd_o   (cmd)
    );

    qdac_regbank i_regs (
        .clk        (clk),
        .rst        (rst),
        .frm_vld_i  (frm_vld),
        .cmd_i      (cmd),
        .status_i   (status_i),
        .data_o     (dac_code_o),
        .gain_o     (gain_o),
        .offs_o     (offset_o),
        .dacctl_o   (dac_ctl_o),
        .slew_o     (slew_o),
        .main_o     (main_ctl_o),
        .dcdc_o     (dcdc_ctl_o),
        .swcmd_o    (sw_ctl_o),
        .resp_o     (resp),
        .resp_vld_o (resp_vld)
    );
endmodule

// File: rtl/qdac_regif_sva.sv
module qdac_regif_sva
    import qdac_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     frm_vld,
    input logic [FRAME_W-1:0]       frm,
    input logic                     rd_pend,
    input logic [NCH*DATA_W-1:0]    code,
    input logic [NCH*DATA_W-1:0]    gain,
    input logic [NCH*DATA_W-1:0]    offs,
    input logic [NCH*DACCTL_W-1:0]  ctl
);
    logic rd_frame;
    logic ctl_frame;
    assign rd_frame  = frm[RD_BIT] && (frm[RSV_HI:RSV_LO] == 2'b00);
    assign ctl_frame = !frm[RD_BIT] && (frm[ADDR_HI:ADDR_HI-2] == 3'b111);

    // R7: reset values seen on the first cycle after reset
    a_r7_reset_values: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (code == '0 && ctl == '0 &&
                        gain == {NCH{GAIN_RST}} && offs == {NCH{OFFS_RST}}));

    // R2: registers move only right after an accepted frame
    a_r2_hold_between_frames: assert property (@(posedge clk) disable iff (rst)
        !$past(frm_vld) |-> ($stable(code) && $stable(gain) && $stable(offs) && $stable(ctl)));

    // R6: channel control changes only through a control-address write
    a_r6_ctl_only_by_ctl_write: assert property (@(posedge clk) disable iff (rst)
        (frm_vld && !ctl_frame) |=> $stable(ctl));

    // R11: a read request arms an answer
    a_r11_read_arms: assert property (@(posedge clk) disable iff (rst)
        (frm_vld && rd_frame) |=> rd_pend);

    // R11: any other accepted frame drops the answer
    a_r11_other_drops: assert property (@(posedge clk) disable iff (rst)
        (frm_vld && !rd_frame) |=> !rd_pend);

    // R1: one accepted-frame pulse per frame
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
        frm_vld |=> !frm_vld);
endmodule

bind quad_dac_regif qdac_regif_sva i_sva (
    .clk     (clk),
    .rst     (rst),
    .frm_vld (frm_vld),
    .frm     (frm_word),
    .rd_pend (resp_vld),
    .code    (dac_code_o),
    .gain    (gain_o),
    .offs    (offset_o),
    .ctl     (dac_ctl_o)
);

// File: tb/test_quad_dac_regif.sv
module test_quad_dac_regif;
    localparam int HALF = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sclk = 1'b0;
    logic         cs_n = 1'b1;
    logic         mosi = 1'b0;
    logic         miso;
    logic [15:0]  status_i = 16'h0000;
    logic [63:0]  dac_code_o, gain_o, offset_o;
    logic [35:0]  dac_ctl_o;
    logic [51:0]  slew_o;
    logic [12:0]  main_ctl_o, dcdc_ctl_o, sw_ctl_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    quad_dac_regif i_quad_dac_regif (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
        .status_i(status_i), .dac_code_o(dac_code_o), .gain_o(gain_o),
        .offset_o(offset_o), .dac_ctl_o(dac_ctl_o), .slew_o(slew_o),
        .main_ctl_o(main_ctl_o), .dcdc_ctl_o(dcdc_ctl_o), .sw_ctl_o(sw_ctl_o)
    );

    function automatic logic [23:0] f_wr(input logic [4:0] a, input logic [15:0] d);
        return {1'b0, 2'b00, a, d};
    endfunction
    function automatic logic [23:0] f_rd(input logic [4:0] a);
        return {1'b1, 2'b00, a, 16'h0000};
    endfunction
    function automatic logic [23:0] f_ctl(input int ch, input logic [2:0] sel, input logic [12:0] v);
        return f_wr(5'h1C | 5'(ch), {sel, v});
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic spi_xfer(input logic [23:0] tx, input int nbits, output logic [23:0] rx);
        rx = '0;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b1;
            mosi = (i < 24) ? tx[23 - i] : 1'b0;
            repeat (HALF) @(negedge clk);
            rx = {rx[22:0], miso};
            sclk = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        cs_n = 1'b1;
        mosi = 1'b0;
        repeat (3 * HALF) @(negedge clk);
    endtask

    task automatic send(input logic [23:0] tx);
        logic [23:0] rx;
        spi_xfer(tx, 24, rx);
    endtask

    task automatic t_reset;
        chk("R7 code reset", dac_code_o, 64'h0);
        chk("R7 gain reset", gain_o, {4{16'hFFFF}});
        chk("R7 offset reset", offset_o, {4{16'h8000}});
        chk("R7 ctl reset", {dac_ctl_o, slew_o}, '0);
        chk("R7 shared reset", {main_ctl_o, dcdc_ctl_o, sw_ctl_o}, '0);
        chk("R12 miso idle after reset", miso, 1'b0);
    endtask

    task automatic t_data_writes;
        for (int c = 0; c < 4; c++) send(f_wr(5'(c), 16'h1111 * 16'(c + 1) ^ 16'hA050));
        chk("R1 R3 codes", dac_code_o,
            {16'h4444 ^ 16'hA050, 16'h3333 ^ 16'hA050, 16'h2222 ^ 16'hA050, 16'h1111 ^ 16'hA050});
        send(f_wr(5'h0A, 16'h7FFE));
        send(f_wr(5'h11, 16'h0123));
        chk("R3 gain ch2", gain_o, {16'hFFFF, 16'h7FFE, 16'hFFFF, 16'hFFFF});
        chk("R3 offset ch1", offset_o, {16'h8000, 16'h8000, 16'h0123, 16'h8000});
    endtask

    task automatic t_ctl_writes;
        send(f_ctl(3, 3'd0, 13'h1ABC));
        chk("R4 ramp ch3", slew_o, {13'h1ABC, 39'h0});
        send(f_ctl(1, 3'd2, 13'h1FFF));
        chk("R5 ctl ch1 keeps 9 bits", dac_ctl_o, {9'h0, 9'h0, 9'h1FF, 9'h0});
        send(f_ctl(2, 3'd2, 13'h0041));
        chk("R5 ctl ch2 outen+range", dac_ctl_o, {9'h0, 9'h041, 9'h1FF, 9'h0});
        send(f_ctl(2, 3'd1, 13'h0123));
        send(f_ctl(0, 3'd3, 13'h0055));
        send(f_ctl(3, 3'd4, 13'h0ABC));
        chk("R4 shared words", {main_ctl_o, dcdc_ctl_o, sw_ctl_o}, {13'h0123, 13'h0055, 13'h0ABC});
    endtask

    task automatic t_ignored;
        logic [63:0] code0, gain0, offs0;
        logic [35:0] ctl0;
        logic [51:0] slew0;
        logic [38:0] sh0;
        code0 = dac_code_o; gain0 = gain_o; offs0 = offset_o;
        ctl0 = dac_ctl_o; slew0 = slew_o; sh0 = {main_ctl_o, dcdc_ctl_o, sw_ctl_o};
        send(f_ctl(1, 3'd5, 13'h1234));
        send(f_ctl(0, 3'd7, 13'h0F0F));
        send(f_wr(5'h05, 16'hDEAD));
        send(f_wr(5'h0D, 16'hBEEF));
        send(f_wr(5'h15, 16'hCAFE));
        send(f_wr(5'h1A, 16'hF00D));
        send(24'h200000 | f_wr(5'h00, 16'h5A5A));
        chk("R6 ignored writes: codes", dac_code_o, code0);
        chk("R6 ignored writes: trims", {gain_o, offset_o} == {gain0, offs0}, 1'b1);
        chk("R6 ignored writes: control", {dac_ctl_o, slew_o, main_ctl_o, dcdc_ctl_o, sw_ctl_o}
            == {ctl0, slew0, sh0}, 1'b1);
        send(24'h1CE000);
        chk("R10 no-op changes nothing", {dac_code_o, gain_o, offset_o, dac_ctl_o, slew_o,
            main_ctl_o, dcdc_ctl_o, sw_ctl_o} == {code0, gain0, offs0, ctl0, slew0, sh0}, 1'b1);
    endtask

    task automatic t_bad_length;
        logic [23:0] rx;
        logic [63:0] code0;
        code0 = dac_code_o;
        spi_xfer(f_wr(5'h00, 16'h9999), 23, rx);
        spi_xfer(f_wr(5'h00, 16'h9999), 25, rx);
        chk("R2 short and long frames drop", dac_code_o, code0);
        spi_xfer(f_rd(5'h09), 25, rx);
        spi_xfer(24'h1CE000, 24, rx);
        chk("R2 long read arms nothing", rx, 24'h0);
        chk("R10 idle response zero", rx, 24'h0);
    endtask

    task automatic rd_check(input string tag, input logic [4:0] a, input logic [15:0] exp);
        logic [23:0] rx;
        spi_xfer(f_rd(a), 24, rx);
        spi_xfer(24'h1CE000, 24, rx);
        chk(tag, rx, {8'h00, exp});
        chk("R12 miso low when deselected", miso, 1'b0);
    endtask

    task automatic t_readback;
        status_i = 16'hC3A5;
        rd_check("R8 read code ch2", 5'h02, 16'h3333 ^ 16'hA050);
        rd_check("R8 read ctl ch1", 5'h05, 16'h01FF);
        rd_check("R8 read gain ch2", 5'h0A, 16'h7FFE);
        rd_check("R8 read offset ch1", 5'h0D, 16'h0123);
        rd_check("R8 read ramp ch3", 5'h17, 16'h1ABC);
        rd_check("R8 read status", 5'h18, 16'hC3A5);
        rd_check("R8 read main", 5'h19, 16'h0123);
        rd_check("R8 read boost", 5'h1A, 16'h0055);
        rd_check("R9 read clear code zero", 5'h11, 16'h0000);
        rd_check("R9 read 0x1B zero", 5'h1B, 16'h0000);
    endtask

    task automatic t_pending;
        logic [23:0] rx;
        spi_xfer(f_rd(5'h00), 24, rx);
        spi_xfer(f_wr(5'h00, 16'h0BAD), 24, rx);
        chk("R8 value captured at request", rx, {8'h00, 16'h1111 ^ 16'hA050});
        chk("R11 response frame still writes", dac_code_o[15:0], 16'h0BAD);
        spi_xfer(24'h1CE000, 24, rx);
        chk("R11 answer sent once", rx, 24'h0);
        spi_xfer(f_rd(5'h0A), 24, rx);
        spi_xfer(f_rd(5'h0C), 24, rx);
        chk("R11 back-to-back first answer", rx, {8'h00, 16'h7FFE});
        spi_xfer(24'h1CE000, 24, rx);
        chk("R11 back-to-back second answer", rx, {8'h00, 16'h8000});
        spi_xfer(24'h600000 | f_rd(5'h0A), 24, rx);
        spi_xfer(24'h1CE000, 24, rx);
        chk("R9 reserved-bit read zero", rx, 24'h0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        t_reset;
        t_data_writes;
        t_ctl_writes;
        t_ignored;
        t_bad_length;
        t_readback;
        t_pending;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule